// File: doc/BRIEF.md
# Phase Accumulator Frequency Synthesizer

This block is the core of a direct digital frequency synthesizer. A phase register of `W` bits advances by a programmable tuning word on every enabled clock. The register's most significant bit is a square wave. Its frequency is the tuning word times the clock frequency divided by 2^W. Each time the phase passes the top of its range, the block raises a one-cycle wrap pulse. Downstream logic can use that pulse as a cycle marker.

Two wrap behaviours can be selected with a mode input. In modular mode the register keeps the remainder after overflow. The long-run average frequency is then exact for any tuning word, at the price of individual periods that differ by up to almost one clock. In clear mode the register drops to zero whenever it wraps. Every period then has the same length, but the frequency departs from the formula whenever the tuning word does not divide 2^W.

A wrap is detected when the truncated W-bit sum comes out smaller than the current phase. The tuning word and the mode are sampled on every clock. A new tuning word therefore takes effect on the next addition, without restarting the phase.

Top module: `phase_accum_synth`

## Requirements
- R1: While `rst_n` is low, `phase` is forced to zero and `wrap_pulse` to 0, asynchronously.
- R2: On a clock edge with `en`=1 and `clear_mode`=0, `phase` becomes (`phase` + `tune_word`) mod 2^W.
- R3: `wrap_pulse` is 1 for the single cycle that follows an enabled clock edge at which the truncated sum `phase`+`tune_word` was smaller than `phase`. In every other cycle it is 0.
- R4: On a clock edge with `en`=1, `clear_mode`=1 and the wrap condition true, `phase` becomes zero. Without a wrap, it loads the sum as in R2.
- R5: A clock edge with `en`=0 leaves `phase` unchanged and leaves `wrap_pulse` at 0 for the following cycle.
- R6: A changed `tune_word` is used by the very next enabled addition, and the phase is not reset by the change.
- R7: `square_out` always equals bit W-1 of `phase`.
- R8: In modular mode, 2^W enabled clocks with a constant tuning word N, starting from zero, return `phase` to zero and produce exactly N wrap pulses.
- R9: In clear mode with a constant nonzero tuning word N, starting from zero, wrap pulses occur every ceil(2^W/N) enabled clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Advance enable; the phase holds while low |
| tune_word | input | W | Phase increment added per enabled clock |
| clear_mode | input | 1 | 0 = modular wrap, 1 = clear phase to zero on wrap |
| phase | output | W | Current phase word |
| square_out | output | 1 | Most significant phase bit (square wave) |
| wrap_pulse | output | 1 | One-cycle marker following each wrap |

## Verification
The properties assume that `en`, `tune_word` and `clear_mode` are stable around each rising edge and are never unknown once reset is released. They also assume that reset is applied before the first clock edge. The bench therefore drives every input on the falling edge and holds reset low from time zero. A small W=6 instance is swept over every tuning word in both modes, starting from reset. Extra sequences toggle the enable and change the tuning word in the middle of a run, so every wrap corner the properties describe is reached with legal inputs only.

// File: rtl/pacc_pkg.sv
package pacc_pkg;

    // Wrap behaviour selected by the clear_mode pin
    typedef enum logic {
        WRAP_MODULAR = 1'b0,
        WRAP_CLEAR   = 1'b1
    } wrap_mode_e;

endpackage

// File: rtl/pacc_step.sv
// Combinational next-phase computation and wrap detection
module pacc_step
    import pacc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] cur_phase,
    input  logic [W-1:0] incr,
    input  wrap_mode_e   mode,
    output logic [W-1:0] nxt_phase,
    output logic         wrap_det
);
    localparam logic [W-1:0] ZERO = '0;

    logic [W-1:0] sum_trunc;

    always_comb begin
        sum_trunc = cur_phase + incr;
        wrap_det  = (sum_trunc < cur_phase);
        unique case (mode)
            WRAP_MODULAR: nxt_phase = sum_trunc;
            WRAP_CLEAR:   nxt_phase = wrap_det ? ZERO : sum_trunc;
            default:      nxt_phase = sum_trunc;
        endcase
    end
endmodule

// File: rtl/pacc_reg.sv
// Phase register and registered wrap marker
module pacc_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] nxt_phase,
    input  logic         wrap_det,
    output logic [W-1:0] phase_q,
    output logic         wrap_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (load) begin
            phase_q <= nxt_phase;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wrap_q <= 1'b0;
        end else begin
            wrap_q <= load & wrap_det;
        end
    end
endmodule

// File: rtl/phase_accum_synth.sv
module phase_accum_synth
    import pacc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] tune_word,
    input  logic         clear_mode,
    output logic [W-1:0] phase,
    output logic         square_out,
    output logic         wrap_pulse
);
    localparam int MSB = W - 1;

    wrap_mode_e   mode_sel;
    logic [W-1:0] nxt_phase;
    logic         wrap_det;

    assign mode_sel = wrap_mode_e'(clear_mode);

    pacc_step #(.W(W)) u_step (
        .cur_phase (phase),
        .incr      (tune_word),
        .mode      (mode_sel),
        .nxt_phase (nxt_phase),
        .wrap_det  (wrap_det)
    );

    pacc_reg #(.W(W)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (en),
        .nxt_phase (nxt_phase),
        .wrap_det  (wrap_det),
        .phase_q   (phase),
        .wrap_q    (wrap_pulse)
    );

    assign square_out = phase[MSB];
endmodule

// File: rtl/pacc_checker.sv
module pacc_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         en,
    input logic [W-1:0] tune_word,
    input logic         clear_mode,
    input logic [W-1:0] phase,
    input logic         square_out,
    input logic         wrap_pulse
);
    logic [W-1:0] sum_w;
    logic         wraps;
    assign sum_w = phase + tune_word;
    assign wraps = sum_w < phase;

    // R1
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |-> (phase == '0 && !wrap_pulse));

    p_modular_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clear_mode) |=> (phase == $past(sum_w)));

    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wraps) |=> wrap_pulse);

    p_nowrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && wraps) |=> !wrap_pulse);

    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && clear_mode && wraps) |=> (phase == '0));

    p_clear_nowrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && clear_mode && !wraps) |=> (phase == $past(sum_w)));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(phase) && !wrap_pulse));

    p_square_r7: assert property (@(posedge clk) disable iff (!rst_n)
        square_out == phase[W-1]);
endmodule

bind phase_accum_synth pacc_checker #(.W(W)) u_pacc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .tune_word  (tune_word),
    .clear_mode (clear_mode),
    .phase      (phase),
    .square_out (square_out),
    .wrap_pulse (wrap_pulse)
);

// File: tb/test_phase_accum_synth.sv
module test_phase_accum_synth;
    localparam int W    = 6;
    localparam int SPAN = 1 << W;
    localparam int MASK = SPAN - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic [W-1:0] tune_word = '0;
    logic         clear_mode = 1'b0;
    logic [W-1:0] phase;
    logic         square_out;
    logic         wrap_pulse;

    int errors = 0;
    int checks = 0;
    int m_phase = 0;
    int m_wrap  = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    phase_accum_synth #(.W(W)) i_phase_accum_synth (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .tune_word  (tune_word),
        .clear_mode (clear_mode),
        .phase      (phase),
        .square_out (square_out),
        .wrap_pulse (wrap_pulse)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        en = 1'b0;
        #1;
        m_phase = 0;
        m_wrap  = 0;
        check("R1 phase", int'(phase), 0);
        check("R1 wrap", int'(wrap_pulse), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive one cycle on the falling edge, predict, then sample at next falling edge
    task automatic step(input bit e, input int n, input bit md);
        int s;
        int w;
        en = e;
        tune_word = n[W-1:0];
        clear_mode = md;
        s = (m_phase + n) & MASK;
        w = (s < m_phase) ? 1 : 0;
        if (e) begin
            m_phase = (md && w == 1) ? 0 : s;
            m_wrap  = w;
        end else begin
            m_wrap = 0;
        end
        @(negedge clk);
        check(md ? "R4 phase" : "R2 phase", int'(phase), m_phase);
        check("R3 wrap", int'(wrap_pulse), m_wrap);
        check("R7 square", int'(square_out), (m_phase >> (W - 1)) & 1);
    endtask

    initial begin
        int wraps;
        int gap;
        int k;
        int held;
        #1;
        check("R1 phase at start", int'(phase), 0);
        check("R1 wrap at start", int'(wrap_pulse), 0);

        // R8: modular sweep over every tuning word
        for (int n = 0; n < SPAN; n++) begin
            do_reset();
            wraps = 0;
            for (int c = 0; c < SPAN; c++) begin
                step(1'b1, n, 1'b0);
                if (wrap_pulse) wraps++;
            end
            check("R8 wrap count", wraps, n);
            check("R8 phase return", int'(phase), 0);
        end

        // R9: clear mode sweep, every nonzero tuning word
        for (int n = 1; n < SPAN; n++) begin
            do_reset();
            k = (SPAN + n - 1) / n;
            gap = 0;
            for (int c = 0; c < 140; c++) begin
                step(1'b1, n, 1'b1);
                gap++;
                if (wrap_pulse) begin
                    check("R9 period", gap, k);
                    gap = 0;
                end
            end
        end

        // R5: enable toggling holds phase and suppresses wrap
        do_reset();
        for (int c = 0; c < 40; c++) begin
            held = int'(phase);
            step(c % 3 != 0, 23, c[3]);
            if (c % 3 == 0) begin
                check("R5 hold", int'(phase), held);
                check("R5 no wrap", int'(wrap_pulse), 0);
            end
        end

        // R6: tuning word change mid-run, no restart
        do_reset();
        for (int c = 0; c < 5; c++) step(1'b1, 7, 1'b0);
        held = int'(phase);
        step(1'b1, 40, 1'b0);
        check("R6 new word used", int'(phase), (held + 40) & MASK);
        for (int c = 0; c < 10; c++) step(1'b1, (c * 13 + 5) & MASK, c[0]);

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (150000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule